// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block brings an SDRAM device from power-on to a usable state and then keeps it refreshed. Once reset is released, it holds the command bus at NOP for a programmable power-up delay. It then issues a precharge of all banks. Next comes a settling phase in which the refresh timer runs with a short interval, and the sequencer puts an auto-refresh command on the bus itself each time that timer expires. After this phase it waits out the refresh recovery time. It then loads the mode register with burst length 4 and CAS latency 2, waits the mode-register delay, and raises `ready`.

From that point the bus stays at NOP and is left to the main memory controller. The refresh timer restarts with the operating interval, which is `REF_UNITS` × 16 clocks. On every expiry it pulses `ref_req` so that the controller can schedule an auto-refresh. Every delay is a parameter counted in clock cycles. The mode word appears on the address bus shifted above the byte-lane, bank and column bits, so that a bridge that strips those bits hands the device the intended value.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low the block shows NOP, `ready` low, `ref_req` low, `cke` high and `addr` zero. The command encoding {cs_n,ras_n,cas_n,we_n} is: NOP = 0111, precharge-all = 0010, auto-refresh = 0001, mode-register load = 0000.
- R2: For the first PWRUP_CYC cycles after reset release (cycle indices 0 to PWRUP_CYC-1), the bus shows NOP with `addr` zero.
- R3: At cycle index PWRUP_CYC a single precharge-all command appears with `addr` bit PALL_BIT (10 by default) set and all other address bits clear. TRP_CYC NOP cycles follow it.
- R4: The settling phase lasts FAST_HOLD_CYC cycles. Counting from the first cycle of the phase, auto-refresh is driven on the bus and `ref_req` pulses in the last cycle of every FAST_UNITS × 16 cycle window. With the defaults these are the phase-relative cycles 31, 63, 95 and 127.
- R5: After the settling phase, TRFC_CYC NOP cycles pass. Then a single mode-register load is issued with `addr` = MODE_VAL << (LANE_W + log2(BANK_CNT) + COL_W). By default this is 0x22 at bit 13, which gives 0x44000.
- R6: TMRD_CYC NOP cycles after the mode-register load, `ready` rises. It then stays high until reset.
- R7: While `ready` is high the bus shows NOP. `ref_req` is a one-cycle pulse every REF_UNITS × 16 cycles, and the first pulse comes REF_UNITS × 16 − 1 cycles after `ready` rises.
- R8: `cke` is high on every cycle. Only the four listed encodings ever appear, and every cycle that issues no command shows NOP with `addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the device, always high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | LANE_W+log2(BANK_CNT)+COL_W+ROW_W | Address word carrying the precharge-all flag or the shifted mode value |
| ready | output | 1 | Initialisation complete |
| ref_req | output | 1 | One-cycle refresh request pulse |

## Verification
The bench builds the block with a 50-cycle power-up delay, TRP_CYC = 2, TRFC_CYC = 4, TMRD_CYC = 2 and REF_UNITS = 3, while keeping the default 32-cycle settling interval and 128-cycle settling hold. With these values every phase boundary is reached within a few hundred cycles. The run also covers four in-phase refreshes, including the one in the final settling cycle right before the recovery wait, and several 48-cycle operating refresh periods. Address geometry stays at its defaults, so the mode word is checked at its real position of 0x44000.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_PALL, ST_TRP, ST_FAST, ST_TRFC, ST_MRS, ST_TMRD, ST_RUN
  } seq_st_e;
endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int FAST_IV = 32,
  parameter int OP_IV   = 736
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic op_sel,
  output logic tick
);
  localparam int MAX_IV = (FAST_IV > OP_IV) ? FAST_IV : OP_IV;
  localparam int CW     = $clog2(MAX_IV + 1);
  localparam logic [CW-1:0] FAST_M1 = CW'(FAST_IV - 1);
  localparam logic [CW-1:0] OP_M1   = CW'(OP_IV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] top_m1;

  assign top_m1 = op_sel ? OP_M1 : FAST_M1;
  assign tick   = en && (cnt_q == top_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!en)           cnt_q <= '0;
    else if (cnt_q == top_m1) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC     = 9600000,
  parameter int TRP_CYC       = 1,
  parameter int FAST_HOLD_CYC = 128,
  parameter int TRFC_CYC      = 4,
  parameter int TMRD_CYC      = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  output sd_cmd_e cmd,
  output logic    ready,
  output logic    tmr_en,
  output logic    tmr_op
);
  localparam int CNT_W = $clog2(PWRUP_CYC + TRP_CYC + FAST_HOLD_CYC + TRFC_CYC + TMRD_CYC + 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic             done;

  always_comb begin
    case (st_q)
      ST_PWR:  lim_m1 = CNT_W'(PWRUP_CYC - 1);
      ST_TRP:  lim_m1 = CNT_W'(TRP_CYC - 1);
      ST_FAST: lim_m1 = CNT_W'(FAST_HOLD_CYC - 1);
      ST_TRFC: lim_m1 = CNT_W'(TRFC_CYC - 1);
      ST_TMRD: lim_m1 = CNT_W'(TMRD_CYC - 1);
      default: lim_m1 = '0;
    endcase
  end

  assign done = (st_q != ST_RUN) && (cnt_q == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PWR;
      cnt_q <= '0;
    end else if (done) begin
      st_q  <= seq_st_e'(st_q + 3'd1);
      cnt_q <= '0;
    end else if (st_q != ST_RUN) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      ST_PALL: cmd = CMD_PALL;
      ST_MRS:  cmd = CMD_MRS;
      ST_FAST: cmd = tick ? CMD_REF : CMD_NOP;
      default: cmd = CMD_NOP;
    endcase
  end

  assign ready  = (st_q == ST_RUN);
  assign tmr_en = (st_q == ST_FAST) || (st_q == ST_RUN);
  assign tmr_op = (st_q == ST_RUN);
endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int MODE_VAL   = 34,
  parameter int MODE_SHIFT = 13,
  parameter int PALL_BIT   = 10
) (
  input  sd_cmd_e           cmd,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] MRS_WORD  = ADDR_W'(MODE_VAL) << MODE_SHIFT;
  localparam logic [ADDR_W-1:0] PALL_WORD = ADDR_W'(1) << PALL_BIT;

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  always_comb begin
    case (cmd)
      CMD_MRS:  addr = MRS_WORD;
      CMD_PALL: addr = PALL_WORD;
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC     = 9600000,
  parameter int TRP_CYC       = 1,
  parameter int FAST_UNITS    = 2,
  parameter int FAST_HOLD_CYC = 128,
  parameter int TRFC_CYC      = 4,
  parameter int TMRD_CYC      = 1,
  parameter int REF_UNITS     = 46,
  parameter int MODE_VAL      = 34,
  parameter int LANE_W        = 2,
  parameter int BANK_CNT      = 4,
  parameter int COL_W         = 9,
  parameter int ROW_W         = 12,
  parameter int PALL_BIT      = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic [LANE_W+$clog2(BANK_CNT)+COL_W+ROW_W-1:0] addr,
  output logic ready,
  output logic ref_req
);
  localparam int BANK_W     = $clog2(BANK_CNT);
  localparam int MODE_SHIFT = LANE_W + BANK_W + COL_W;
  localparam int ADDR_W     = MODE_SHIFT + ROW_W;
  localparam int FAST_IV    = FAST_UNITS * 16;
  localparam int OP_IV      = REF_UNITS * 16;

  sd_cmd_e cmd;
  logic    tick, tmr_en, tmr_op;

  assign cke     = 1'b1;
  assign ref_req = tick;

  sdram_ref_timer #(.FAST_IV(FAST_IV), .OP_IV(OP_IV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .op_sel(tmr_op), .tick(tick)
  );

  sdram_init_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .TRP_CYC(TRP_CYC), .FAST_HOLD_CYC(FAST_HOLD_CYC),
    .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd),
    .ready(ready), .tmr_en(tmr_en), .tmr_op(tmr_op)
  );

  sdram_cmd_drive #(
    .ADDR_W(ADDR_W), .MODE_VAL(MODE_VAL), .MODE_SHIFT(MODE_SHIFT), .PALL_BIT(PALL_BIT)
  ) u_drv (
    .cmd(cmd), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W     = 25,
  parameter int MODE_VAL   = 34,
  parameter int MODE_SHIFT = 13,
  parameter int PALL_BIT   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              ref_req
);
  logic [3:0] bus;
  assign bus = {cs_n, ras_n, cas_n, we_n};

  AST_PALL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bus == 4'b0010 |-> addr == (ADDR_W'(1) << PALL_BIT)); // R3
  AST_REF_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus == 4'b0001 |-> ref_req && !ready); // R4
  AST_MODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bus == 4'b0000 |-> addr == (ADDR_W'(MODE_VAL) << MODE_SHIFT)); // R5
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R6
  AST_READY_AFTER_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(bus) == 4'b0111); // R6
  AST_RUN_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> bus == 4'b0111 && addr == '0); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |=> !ref_req); // R7
  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (bus == 4'b0111 || bus == 4'b0010 || bus == 4'b0001 || bus == 4'b0000)); // R8
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W(ADDR_W), .MODE_VAL(MODE_VAL), .MODE_SHIFT(MODE_SHIFT), .PALL_BIT(PALL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ready(ready), .ref_req(ref_req)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
  localparam int PWR   = 50;
  localparam int TRP   = 2;
  localparam int HOLD  = 128;
  localparam int FIV   = 32;
  localparam int TRFC  = 4;
  localparam int TMRD  = 2;
  localparam int RUNIT = 3;
  localparam int OIV   = RUNIT * 16;
  localparam int AW    = 25;
  localparam int NCYC  = 400;

  localparam int K_PALL = PWR;
  localparam int K_F0   = PWR + 1 + TRP;
  localparam int K_FEND = K_F0 + HOLD - 1;
  localparam int K_MRS  = K_FEND + 1 + TRFC;
  localparam int K_RDY  = K_MRS + 1 + TMRD;

  typedef struct packed {
    logic [3:0]    bus;
    logic [AW-1:0] addr;
    logic          rdy;
    logic          req;
    logic          cke;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, ref_req;
  logic [AW-1:0] addr;

  int checks = 0;
  int fails  = 0;
  int idx    = 0;
  bit started = 0;
  bit finished = 0;
  item_t q[$];

  always #4 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYC(PWR), .TRP_CYC(TRP), .FAST_UNITS(2), .FAST_HOLD_CYC(HOLD),
    .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .REF_UNITS(RUNIT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ready(ready), .ref_req(ref_req)
  );

  function automatic item_t expect_at(int k);
    item_t e;
    e.bus = 4'b0111; e.addr = '0; e.rdy = 1'b0; e.req = 1'b0; e.cke = 1'b1;
    if (k == K_PALL) begin
      e.bus = 4'b0010; e.addr = AW'(1) << 10;
    end else if (k >= K_F0 && k <= K_FEND && ((k - K_F0) % FIV) == FIV - 1) begin
      e.bus = 4'b0001; e.req = 1'b1;
    end else if (k == K_MRS) begin
      e.bus = 4'b0000; e.addr = AW'(25'h44000);
    end else if (k >= K_RDY) begin
      e.rdy = 1'b1;
      e.req = (((k - K_RDY) % OIV) == OIV - 1);
    end
    return e;
  endfunction

  function automatic string tag_at(int k);
    if (k < K_PALL)      return "R2";
    if (k < K_F0)        return "R3";
    if (k <= K_FEND)     return "R4";
    if (k <= K_MRS)      return "R5";
    if (k <= K_RDY)      return "R6";
    return "R7";
  endfunction

  task automatic drive_expected();
    for (int k = 0; k < NCYC; k++) q.push_back(expect_at(k));
  endtask

  // monitor: pops one expected item per cycle and compares with the ports
  initial begin
    wait (started);
    while (q.size() > 0) begin
      #1;
      begin
        item_t e, a;
        e = q.pop_front();
        a.bus = {cs_n, ras_n, cas_n, we_n}; a.addr = addr; a.rdy = ready;
        a.req = ref_req; a.cke = cke;
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s (R8 cke/idle) cycle %0d: actual bus=%b addr=%h rdy=%b req=%b cke=%b expected bus=%b addr=%h rdy=%b req=%b cke=%b",
                   tag_at(idx), idx, a.bus, a.addr, a.rdy, a.req, a.cke,
                   e.bus, e.addr, e.rdy, e.req, e.cke);
        end
      end
      idx++;
      @(negedge clk);
    end
    finished = 1;
  end

  initial begin
    for (int w = 0; w < 200000; w++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    drive_expected();
    repeat (3) @(negedge clk);
    // R1 reset state, held for several edges
    for (int r = 0; r < 3; r++) begin
      checks++;
      if ({cs_n, ras_n, cas_n, we_n} !== 4'b0111 || ready !== 1'b0 || ref_req !== 1'b0 ||
          cke !== 1'b1 || addr !== '0) begin
        fails++;
        $display("FAIL R1 reset: actual bus=%b rdy=%b req=%b cke=%b addr=%h expected bus=0111 rdy=0 req=0 cke=1 addr=0",
                 {cs_n, ras_n, cas_n, we_n}, ready, ref_req, cke, addr);
      end
      @(negedge clk);
    end
    rst_n = 1'b1;
    started = 1;
    wait (finished);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule